// File: doc/BRIEF.md
# Register Write Guard with Calendar Freeze Handshake

This block sits in front of a real-time clock's register file. Software first writes two fixed key bytes in order to open write access. Until then, every write to the control, alarm, calendar and divider registers is dropped. The block decodes the register bus, decides which writes may pass, and hands the register storage outside it a per-class write enable.

The block also runs two handshakes with the slow calendar domain, which it sees as a one-cycle tick pulse. In the first, software raises an init request. A fixed number of slow ticks later the block reports that the calendar is frozen, and only then are time, date and divider writes passed on. In the second, software clears a shadow-synchronized flag. The block counts shadow refreshes, which happen on every tick while the calendar runs, and sets the flag again once the readable copies are fresh. A sticky flag records that a date has been written since reset.

Top module: `rtc_write_guard`

## Requirements
- R1: After reset the block is locked, the init request, init-active, synchronized and calendar-initialized flags are all 0, and the status register reads 0.
- R2: A write of 0xCA to the key register (word address 1; only data bits 7:0 compared) followed directly by a write of 0x53 sets `unlocked` from the edge of the second write; any other second value leaves the block locked.
- R3: Any key write other than 0x53 directly after 0xCA locks the block at its edge, including 0xFF and a new 0xCA while unlocked; keys in reversed order do not unlock.
- R4: A write to any other address between the two keys restarts the sequence from locked; cycles with no write between the keys do not.
- R5: While locked, `ctrlWrEn` and `calWrEn` stay 0 and a status write cannot change the init request bit.
- R6: When unlocked, a write to the control (address 2) or alarm (address 3) register raises `ctrlWrEn` in the same cycle; no other address does.
- R7: `calWrEn` is raised in the cycle of a write to time (4), date (5) or divider (6) only while unlocked and `initActive` is 1.
- R8: Writing status bit 7 = 1 while unlocked requests init; `initActive` rises at the edge of the second slow tick seen after the request bit is stored (a tick in the writing cycle does not count).
- R9: Writing status bit 7 = 0 (while unlocked) drops `initActive` one cycle after the request reads 0, and discards partially counted ticks.
- R10: `shadowLoad` pulses with each slow tick while `initActive` is 0 and stays 0 during init mode.
- R11: A status write with bit 5 = 0 clears `shadowSync` whether locked or not; bit 5 = 1 leaves it; the flag sets at the edge of the second `shadowLoad` after the clear (reset counts as a clear), and a clear in the same cycle as a refresh wins and discards that refresh.
- R12: `calInitDone` sets on an accepted date write and holds until reset.
- R13: The status register (address 0) reads bit 7 init request, bit 6 init active, bit 5 synchronized, bit 4 calendar initialized, other bits 0; the key register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRdata | output | 32 | Read data for the addressed register |
| slowTick | input | 1 | One-cycle pulse per slow calendar clock cycle |
| unlocked | output | 1 | Key sequence completed, protected writes allowed |
| ctrlWrEn | output | 1 | Accepted write to control or alarm register |
| calWrEn | output | 1 | Accepted write to time, date or divider register |
| initActive | output | 1 | Calendar frozen for update |
| shadowSync | output | 1 | Shadow time and date copies are fresh |
| shadowLoad | output | 1 | Refresh pulse for the shadow copies |
| calInitDone | output | 1 | A date has been written since reset |

## Verification
The clear of the synchronized flag and a shadow refresh can land in the same cycle. The bench provokes this by writing status bit 5 = 0 with the slow tick held high in the same cycle, after one refresh has already been counted. The result is judged correct when the flag still needs two further ticks to set. The init request write is likewise issued together with a tick, and init mode must then still wait two further ticks.

// File: rtl/rtc_guard_pkg.sv
package rtc_guard_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 8;
  localparam int NUM_ADDR = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_KEY    = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_ALARM  = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_TIME   = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_DATE   = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_DIV    = 4'd6;

  localparam logic [KEY_W-1:0] KEY_OPEN_A = 8'hCA;
  localparam logic [KEY_W-1:0] KEY_OPEN_B = 8'h53;

  localparam int BIT_REQ  = 7;
  localparam int BIT_ACT  = 6;
  localparam int BIT_SYNC = 5;
  localparam int BIT_DONE = 4;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } keyState_e;

  typedef struct packed {
    logic keyWr;
    logic keyFirst;
    logic keySecond;
    logic otherWr;
    logic statWr;
    logic statReq;
    logic statClrSync;
  } busStrb_t;

  typedef struct packed {
    logic unlocked;
    logic initReq;
    logic initActive;
    logic shadowSync;
  } ctlState_t;
endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import rtc_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  input  ctlState_t         ctl,
  output busStrb_t          strb,
  output logic [DATA_W-1:0] busRdata,
  output logic              ctrlWrEn,
  output logic              calWrEn,
  output logic              calInitDone
);
  logic [NUM_ADDR-1:0] regHit;
  logic unusedData;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : gHit
    assign regHit[g] = (busAddr == ADDR_W'(g));
  end

  assign unusedData = ^busWdata[DATA_W-1:KEY_W];

  always_comb begin
    strb.keyWr       = busWe & regHit[ADDR_KEY];
    strb.keyFirst    = strb.keyWr & (busWdata[KEY_W-1:0] == KEY_OPEN_A);
    strb.keySecond   = strb.keyWr & (busWdata[KEY_W-1:0] == KEY_OPEN_B);
    strb.otherWr     = busWe & ~regHit[ADDR_KEY];
    strb.statWr      = busWe & regHit[ADDR_STATUS];
    strb.statReq     = busWdata[BIT_REQ];
    strb.statClrSync = strb.statWr & ~busWdata[BIT_SYNC];
  end

  logic ctrlHit, calHit;
  assign ctrlHit  = regHit[ADDR_CTRL] | regHit[ADDR_ALARM];
  assign calHit   = regHit[ADDR_TIME] | regHit[ADDR_DATE] | regHit[ADDR_DIV];
  assign ctrlWrEn = busWe & ctl.unlocked & ctrlHit;
  assign calWrEn  = busWe & ctl.unlocked & ctl.initActive & calHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) calInitDone <= 1'b0;
    else if (calWrEn && regHit[ADDR_DATE]) calInitDone <= 1'b1;
  end

  always_comb begin
    busRdata = '0;
    if (regHit[ADDR_STATUS]) begin
      busRdata[BIT_REQ]  = ctl.initReq;
      busRdata[BIT_ACT]  = ctl.initActive;
      busRdata[BIT_SYNC] = ctl.shadowSync;
      busRdata[BIT_DONE] = calInitDone;
    end
  end

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    calInitDone |=> calInitDone); // R12
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import rtc_guard_pkg::*;
#(
  parameter int ACK_TICKS  = 2,
  parameter int SYNC_TICKS = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      slowTick,
  input  busStrb_t  strb,
  output ctlState_t ctl,
  output logic      shadowLoad
);
  localparam int ACK_W  = $clog2(ACK_TICKS > 1 ? ACK_TICKS : 2);
  localparam int SYNC_W = $clog2(SYNC_TICKS > 1 ? SYNC_TICKS : 2);

  keyState_e keyState, keyNext;
  logic [ACK_W-1:0]  ackCnt;
  logic [SYNC_W-1:0] syncCnt;
  logic initReq, initActive, shadowSync;

  always_comb begin
    keyNext = keyState;
    if (strb.keyWr) begin
      if (strb.keyFirst) keyNext = KS_HALF;
      else if (strb.keySecond && keyState == KS_HALF) keyNext = KS_OPEN;
      else keyNext = KS_LOCKED;
    end else if (strb.otherWr && keyState == KS_HALF) begin
      keyNext = KS_LOCKED;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keyState <= KS_LOCKED;
    else       keyState <= keyNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) initReq <= 1'b0;
    else if (strb.statWr && keyState == KS_OPEN) initReq <= strb.statReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initActive <= 1'b0;
      ackCnt     <= '0;
    end else if (!initReq) begin
      initActive <= 1'b0;
      ackCnt     <= '0;
    end else if (!initActive && slowTick) begin
      if (ackCnt == ACK_W'(ACK_TICKS - 1)) begin
        initActive <= 1'b1;
        ackCnt     <= '0;
      end else begin
        ackCnt <= ackCnt + 1'b1;
      end
    end
  end

  assign shadowLoad = slowTick & ~initActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowSync <= 1'b0;
      syncCnt    <= '0;
    end else if (strb.statClrSync) begin
      shadowSync <= 1'b0;
      syncCnt    <= '0;
    end else if (!shadowSync && shadowLoad) begin
      if (syncCnt == SYNC_W'(SYNC_TICKS - 1)) begin
        shadowSync <= 1'b1;
        syncCnt    <= '0;
      end else begin
        syncCnt <= syncCnt + 1'b1;
      end
    end
  end

  assign ctl.unlocked   = (keyState == KS_OPEN);
  assign ctl.initReq    = initReq;
  assign ctl.initActive = initActive;
  assign ctl.shadowSync = shadowSync;

  AST_UNLOCK_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.unlocked) |-> $past(strb.keySecond)); // R2
  AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.keyWr && !strb.keySecond) |=> !ctl.unlocked); // R3
  AST_HALF_BROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (keyState == KS_HALF && strb.otherWr) |=> !ctl.unlocked); // R4
  AST_INIT_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initActive) |-> $past(initReq && slowTick)); // R8
  AST_INIT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !initReq |=> !initActive); // R9
  AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.statClrSync |=> !shadowSync); // R11
endmodule

// File: rtl/rtc_write_guard.sv
module rtc_write_guard
  import rtc_guard_pkg::*;
#(
  parameter int ACK_TICKS  = 2,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              busWe,
  output logic [DATA_W-1:0] busRdata,
  input  logic              slowTick,
  output logic              unlocked,
  output logic              ctrlWrEn,
  output logic              calWrEn,
  output logic              initActive,
  output logic              shadowSync,
  output logic              shadowLoad,
  output logic              calInitDone
);
  busStrb_t  strb;
  ctlState_t ctl;

  guard_datapath i_datapath (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .ctl(ctl), .strb(strb), .busRdata(busRdata),
    .ctrlWrEn(ctrlWrEn), .calWrEn(calWrEn), .calInitDone(calInitDone)
  );

  guard_ctrl #(.ACK_TICKS(ACK_TICKS), .SYNC_TICKS(SYNC_TICKS)) i_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick), .strb(strb),
    .ctl(ctl), .shadowLoad(shadowLoad)
  );

  assign unlocked   = ctl.unlocked;
  assign initActive = ctl.initActive;
  assign shadowSync = ctl.shadowSync;
endmodule

// File: tb/test_rtc_write_guard.sv
`timescale 1ns/1ps
module test_rtc_write_guard;
  localparam logic [3:0] A_STAT = 4'd0, A_KEY = 4'd1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busWe = 1'b0;
  logic slowTick = 1'b0;
  logic [31:0] busRdata;
  logic unlocked, ctrlWrEn, calWrEn, initActive, shadowSync, shadowLoad, calInitDone;
  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_write_guard i_rtc_write_guard (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRdata(busRdata), .slowTick(slowTick),
    .unlocked(unlocked), .ctrlWrEn(ctrlWrEn), .calWrEn(calWrEn),
    .initActive(initActive), .shadowSync(shadowSync),
    .shadowLoad(shadowLoad), .calInitDone(calInitDone)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; slowTick = tk;
    @(negedge clk);
    busWe = 1'b0; slowTick = 1'b0;
  endtask

  task automatic wrChk(input logic [3:0] a, input logic [31:0] d,
                       input bit expCtrl, input bit expCal, input string tag);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    #1;
    check({tag, " ctrlWrEn"}, 32'(ctrlWrEn), 32'(expCtrl));
    check({tag, " calWrEn"}, 32'(calWrEn), 32'(expCal));
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic tick(input bit expLoad);
    @(negedge clk);
    slowTick = 1'b1;
    #1;
    check("R10 shadowLoad", 32'(shadowLoad), 32'(expLoad));
    @(negedge clk);
    slowTick = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    busAddr = a;
    #1;
    check(tag, busRdata, exp);
  endtask

  task automatic unlock();
    wr(A_KEY, 32'hCA, 1'b0);
    wr(A_KEY, 32'h53, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 unlocked", 32'(unlocked), 0);
    check("R1 initActive", 32'(initActive), 0);
    check("R1 shadowSync", 32'(shadowSync), 0);
    check("R1 calInitDone", 32'(calInitDone), 0);
    rd(A_STAT, 32'h0, "R1 R13 status after reset");
    // R11 reset acts as a pending clear
    tick(1'b1);
    check("R11 sync after one refresh", 32'(shadowSync), 0);
    tick(1'b1);
    check("R11 sync after two refreshes", 32'(shadowSync), 1);

    // R2 sweep of the second key
    for (int v = 0; v < 256; v++) begin
      wr(A_KEY, 32'hFF, 1'b0);
      wr(A_KEY, 32'hCA, 1'b0);
      wr(A_KEY, 32'(v), 1'b0);
      check("R2 second key sweep", 32'(unlocked), 32'(v == 8'h53));
    end
    // R3 sweep of the first key
    for (int v = 0; v < 256; v++) begin
      wr(A_KEY, 32'hFF, 1'b0);
      wr(A_KEY, 32'(v), 1'b0);
      wr(A_KEY, 32'h53, 1'b0);
      check("R3 first key sweep", 32'(unlocked), 32'(v == 8'hCA));
    end
    wr(A_KEY, 32'hFF, 1'b0);
    check("R3 0xFF relocks", 32'(unlocked), 0);
    unlock();
    wr(A_KEY, 32'hCA, 1'b0);
    check("R3 new 0xCA relocks", 32'(unlocked), 0);
    wr(A_KEY, 32'hFF, 1'b0);
    wr(A_KEY, 32'h53, 1'b0);
    wr(A_KEY, 32'hCA, 1'b0);
    check("R3 reversed order", 32'(unlocked), 0);
    // R2 upper data bits ignored
    wr(A_KEY, 32'hFF, 1'b0);
    wr(A_KEY, 32'h1234_56CA, 1'b0);
    wr(A_KEY, 32'hABCD_EF53, 1'b0);
    check("R2 only low byte compared", 32'(unlocked), 1);

    // R4 a write between the keys restarts
    for (int a = 0; a < 16; a++) begin
      if (a == 1) continue;
      wr(A_KEY, 32'hFF, 1'b0);
      wr(A_KEY, 32'hCA, 1'b0);
      wr(4'(a), 32'h20, 1'b0);
      wr(A_KEY, 32'h53, 1'b0);
      check("R4 write between keys", 32'(unlocked), 0);
    end
    wr(A_KEY, 32'hCA, 1'b0);
    busAddr = 4'd5;
    repeat (3) @(negedge clk);
    wr(A_KEY, 32'h53, 1'b0);
    check("R4 idle gap keeps sequence", 32'(unlocked), 1);

    // R5 locked sweep
    wr(A_KEY, 32'hFF, 1'b0);
    for (int a = 0; a < 16; a++) begin
      if (a == 1) continue;
      wrChk(4'(a), 32'hA0, 1'b0, 1'b0, "R5 locked");
    end
    rd(A_STAT, 32'h20, "R5 init request unchanged while locked");

    // R6 unlocked sweep outside init
    unlock();
    for (int a = 0; a < 16; a++) begin
      if (a == 1) continue;
      wrChk(4'(a), 32'h20, (a == 2 || a == 3), 1'b0, "R6 R7 unlocked no init");
    end
    check("R12 no date written", 32'(calInitDone), 0);

    // R8 init handshake, tick in the request cycle does not count
    wr(A_STAT, 32'hA0, 1'b1);
    check("R8 not active after request", 32'(initActive), 0);
    tick(1'b1);
    check("R8 not active after one tick", 32'(initActive), 0);
    tick(1'b1);
    check("R8 active after two ticks", 32'(initActive), 1);
    tick(1'b0);

    // R7 sweep in init mode, R12 date sets the flag
    for (int a = 0; a < 16; a++) begin
      if (a == 1) continue;
      wrChk(4'(a), 32'hA0, (a == 2 || a == 3), (a >= 4 && a <= 6), "R7 init mode");
      check("R12 calInitDone", 32'(calInitDone), 32'(a >= 5));
    end
    rd(A_STAT, 32'hF0, "R13 status all set");
    rd(A_KEY, 32'h0, "R13 key reads zero");

    // R9 leaving init and counter restart
    wr(A_STAT, 32'h20, 1'b0);
    check("R9 still active one cycle", 32'(initActive), 1);
    @(negedge clk);
    check("R9 dropped", 32'(initActive), 0);
    wr(A_STAT, 32'hA0, 1'b0);
    tick(1'b1);
    wr(A_STAT, 32'h20, 1'b0);
    @(negedge clk);
    wr(A_STAT, 32'hA0, 1'b0);
    tick(1'b1);
    check("R9 partial count discarded", 32'(initActive), 0);
    tick(1'b1);
    check("R9 active after fresh count", 32'(initActive), 1);
    wr(A_STAT, 32'h20, 1'b0);
    @(negedge clk);
    check("R9 left init", 32'(initActive), 0);
    check("R12 sticky after init", 32'(calInitDone), 1);

    // R11 clear while locked, refresh counting, collision
    wr(A_KEY, 32'hFF, 1'b0);
    wr(A_STAT, 32'h00, 1'b0);
    check("R11 cleared while locked", 32'(shadowSync), 0);
    tick(1'b1);
    check("R11 one refresh", 32'(shadowSync), 0);
    tick(1'b1);
    check("R11 set after two", 32'(shadowSync), 1);
    wr(A_STAT, 32'h20, 1'b0);
    check("R11 bit5 one keeps flag", 32'(shadowSync), 1);
    wr(A_STAT, 32'h00, 1'b0);
    tick(1'b1);
    wr(A_STAT, 32'h00, 1'b1);
    check("R11 clear wins over refresh", 32'(shadowSync), 0);
    tick(1'b1);
    check("R11 collision refresh discarded", 32'(shadowSync), 0);
    tick(1'b1);
    check("R11 set after collision", 32'(shadowSync), 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule